// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

The block holds four equal-width data registers in two banks: bank A (stages A1, A2) and bank B (stages B1, B2). A 2-bit instruction, sampled on each rising clock edge, decides how the registers move on that edge. They can act as one four-deep shift chain, as a two-deep pipeline in bank A alone, or as a two-deep pipeline in bank B alone. They can also hold every value unchanged.

A separate 2-bit select reads any one of the four registers at the output. The select path is combinational, so a different stage can be read in the same cycle without waiting for a clock. An active-low output enable gates the output. Tri-state is modelled as a data bus plus an enable flag, which keeps the core synthesizable.

A typical use is a small delay line whose depth can be changed at run time. Another is a pair of short independent pipelines that share one read port.

Top module: `mlpipe_reg`

## Requirements
- R1: A synchronous active-high reset `rst` sampled on a rising edge clears all four registers to zero. Reading every select value after that edge gives zero.
- R2: With instruction 0 (chain mode), each rising edge moves data along the whole chain in one step: A1 takes `din`, A2 takes the old A1, B1 takes the old A2, and B2 takes the old B1.
- R3: With instruction 1 (bank B mode), each rising edge loads `din` into B1 and moves the old B1 into B2. A1 and A2 keep their values.
- R4: With instruction 2 (bank A mode), each rising edge loads `din` into A1 and moves the old A1 into A2. B1 and B2 keep their values.
- R5: With instruction 3 (hold), no register changes on the clock edge, whatever `din` carries.
- R6: The select `sel` reads a register combinationally, with this encoding: 3 gives A1, 2 gives A2, 1 gives B1, 0 gives B2. A change of `sel` between edges shows on `dout` with no clock.
- R7: When `oeN` is high, `doutEn` is 0 and `dout` is all zeros. When `oeN` is low, `doutEn` is 1 and `dout` carries the selected register.
- R8: Reset takes priority over the instruction. A reset edge with instruction 0 and non-zero `din` still leaves all registers at zero.
- R9: The instruction acts with no extra latency. Changing the mode from one edge to the next in the middle of a stream applies the new mode on the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | WIDTH | Data word entering the pipeline |
| instr | input | 2 | Instruction: 0 chain, 1 bank B, 2 bank A, 3 hold |
| sel | input | 2 | Read select: 3 A1, 2 A2, 1 B1, 0 B2 |
| oeN | input | 1 | Active-low output enable |
| dout | output | WIDTH | Selected register, or zero when disabled |
| doutEn | output | 1 | High when the output is actively driven |

## Verification
The bench keeps its own model of all four registers and reads every select value after each edge. This catches a wrong select encoding or a bank that moves when it should hold.

Several sequences switch between chain mode and the single-bank modes in the middle of a stream. A design that took B1 from the wrong source, or that applied a new mode one edge late, would leave the wrong word in B1 or B2.

Hold edges are driven with changing `din`, so a leaky hold shows up as a changed read. A reset edge is driven with chain mode and non-zero data, which exposes a design that gives the instruction priority over reset. The output is also read with the enable off, so a design that still drives data there fails the check.

// File: rtl/mlpipe_reg_pkg.sv
package mlpipe_reg_pkg;

  localparam int NUM_STAGES = 4;
  localparam int STAGE_A1 = 0;
  localparam int STAGE_A2 = 1;
  localparam int STAGE_B1 = 2;
  localparam int STAGE_B2 = 3;

  typedef enum logic [1:0] {
    INS_CHAIN = 2'd0,
    INS_BANKB = 2'd1,
    INS_BANKA = 2'd2,
    INS_HOLD  = 2'd3
  } instr_e;

  typedef enum logic [1:0] {
    SEL_B2 = 2'd0,
    SEL_B1 = 2'd1,
    SEL_A2 = 2'd2,
    SEL_A1 = 2'd3
  } sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  clr;
    logic [NUM_STAGES-1:0] load;
    logic                  b1FromChain;
  } strobe_t;

endpackage

// File: rtl/mlpipe_reg_ctrl.sv
module mlpipe_reg_ctrl
  import mlpipe_reg_pkg::*;
(
  input  logic       rst,
  input  logic [1:0] instr,
  output strobe_t    strb
);

  instr_e mode;

  assign mode = instr_e'(instr);

  always_comb begin
    strb             = '0;
    strb.clr         = rst;
    strb.b1FromChain = (mode == INS_CHAIN);
    if (!rst) begin
      unique case (mode)
        INS_CHAIN: strb.load = '1;
        INS_BANKB: begin
          strb.load[STAGE_B1] = 1'b1;
          strb.load[STAGE_B2] = 1'b1;
        end
        INS_BANKA: begin
          strb.load[STAGE_A1] = 1'b1;
          strb.load[STAGE_A2] = 1'b1;
        end
        INS_HOLD: strb.load = '0;
        default:  strb.load = '0;
      endcase
    end
  end

endmodule

// File: rtl/mlpipe_reg_datapath.sv
module mlpipe_reg_datapath
  import mlpipe_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       sel,
  input  logic             oeN,
  output logic [WIDTH-1:0] dout,
  output logic             doutEn,
  output logic [WIDTH-1:0] stageQ [NUM_STAGES]
);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : gStage
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] q;

    if (g == STAGE_A1) begin : gHead
      assign src = din;
    end else if (g == STAGE_B1) begin : gBankJoin
      // B1 heads bank B in single-bank mode, follows A2 in chain mode
      assign src = strb.b1FromChain ? stageQ[g-1] : din;
    end else begin : gFollow
      assign src = stageQ[g-1];
    end

    always_ff @(posedge clk) begin
      if (strb.clr) begin
        q <= '0;
      end else if (strb.load[g]) begin
        q <= src;
      end
    end

    assign stageQ[g] = q;
  end

  logic [WIDTH-1:0] picked;

  always_comb begin
    unique case (sel_e'(sel))
      SEL_A1:  picked = stageQ[STAGE_A1];
      SEL_A2:  picked = stageQ[STAGE_A2];
      SEL_B1:  picked = stageQ[STAGE_B1];
      SEL_B2:  picked = stageQ[STAGE_B2];
      default: picked = '0;
    endcase
  end

  assign doutEn = ~oeN;
  assign dout   = doutEn ? picked : '0;

endmodule

// File: rtl/mlpipe_reg.sv
module mlpipe_reg
  import mlpipe_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       instr,
  input  logic [1:0]       sel,
  input  logic             oeN,
  output logic [WIDTH-1:0] dout,
  output logic             doutEn
);

  strobe_t          strb;
  logic [WIDTH-1:0] stageQ [NUM_STAGES];
  logic [WIDTH-1:0] qA1, qA2, qB1, qB2;

  mlpipe_reg_ctrl u_ctrl (
    .rst   (rst),
    .instr (instr),
    .strb  (strb)
  );

  mlpipe_reg_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .strb   (strb),
    .din    (din),
    .sel    (sel),
    .oeN    (oeN),
    .dout   (dout),
    .doutEn (doutEn),
    .stageQ (stageQ)
  );

  assign qA1 = stageQ[STAGE_A1];
  assign qA2 = stageQ[STAGE_A2];
  assign qB1 = stageQ[STAGE_B1];
  assign qB2 = stageQ[STAGE_B2];

endmodule

// File: rtl/mlpipe_reg_chk.sv
module mlpipe_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] din,
  input logic [1:0]       instr,
  input logic [1:0]       sel,
  input logic             oeN,
  input logic [WIDTH-1:0] dout,
  input logic             doutEn,
  input logic [WIDTH-1:0] qA1,
  input logic [WIDTH-1:0] qA2,
  input logic [WIDTH-1:0] qB1,
  input logic [WIDTH-1:0] qB2
);

  assert_chain_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (instr == 2'd0) |=> (qA1 == $past(din) && qA2 == $past(qA1) &&
                         qB1 == $past(qA2) && qB2 == $past(qB1)));

  assert_bankb_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (instr == 2'd1) |=> (qB1 == $past(din) && qB2 == $past(qB1) &&
                         $stable(qA1) && $stable(qA2)));

  assert_banka_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (instr == 2'd2) |=> (qA1 == $past(din) && qA2 == $past(qA1) &&
                         $stable(qB1) && $stable(qB2)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (instr == 2'd3) |=> ($stable(qA1) && $stable(qA2) && $stable(qB1) && $stable(qB2)));

  assert_select_map_R6: assert property (@(posedge clk) disable iff (rst)
    !oeN |-> (dout == ((sel == 2'd3) ? qA1 : (sel == 2'd2) ? qA2 :
                       (sel == 2'd1) ? qB1 : qB2)));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    oeN |-> (!doutEn && dout == '0));

endmodule

bind mlpipe_reg mlpipe_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .din    (din),
  .instr  (instr),
  .sel    (sel),
  .oeN    (oeN),
  .dout   (dout),
  .doutEn (doutEn),
  .qA1    (qA1),
  .qA2    (qA2),
  .qB1    (qB1),
  .qB2    (qB2)
);

// File: tb/mlpipe_reg_bench.sv
`timescale 1ns/1ps
module mlpipe_reg_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [1:0]   instr = 2'd3;
  logic [1:0]   sel = 2'd0;
  logic         oeN = 1'b0;
  logic [W-1:0] dout;
  logic         doutEn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] mA1 = '0, mA2 = '0, mB1 = '0, mB2 = '0;

  logic [W-1:0] expVal[$];
  logic         expEn[$];
  string        expTag[$];
  event         sampleEv;

  always #10 clk = ~clk;

  mlpipe_reg #(.WIDTH(W)) u_mlpipe_reg (
    .clk(clk), .rst(rst), .din(din), .instr(instr),
    .sel(sel), .oeN(oeN), .dout(dout), .doutEn(doutEn)
  );

  // Monitor: pop expected items and compare against the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (expVal.size() > 0) begin
        logic [W-1:0] ev;
        logic         ee;
        string        et;
        ev = expVal.pop_front();
        ee = expEn.pop_front();
        et = expTag.pop_front();
        checks++;
        if (dout !== ev || doutEn !== ee) begin
          failures++;
          $display("FAIL %s: sel=%0d dout=%h en=%b expected dout=%h en=%b",
                   et, sel, dout, doutEn, ev, ee);
        end
      end
    end
  end

  function automatic logic [W-1:0] modelPick(input logic [1:0] s);
    case (s)
      2'd3:    return mA1;
      2'd2:    return mA2;
      2'd1:    return mB1;
      default: return mB2;
    endcase
  endfunction

  task automatic readAll(input string tag);
    for (int s = 3; s >= 0; s--) begin
      sel = s[1:0];
      #1;
      expVal.push_back(oeN ? '0 : modelPick(s[1:0]));
      expEn.push_back(~oeN);
      expTag.push_back(tag);
      ->sampleEv;
      #1;
    end
  endtask

  task automatic step(input logic [1:0] ins, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    rst = 1'b0;
    instr = ins;
    din = d;
    @(posedge clk);
    #1;
    case (ins)
      2'd0: begin mB2 = mB1; mB1 = mA2; mA2 = mA1; mA1 = d; end
      2'd1: begin mB2 = mB1; mB1 = d; end
      2'd2: begin mA2 = mA1; mA1 = d; end
      default: ;
    endcase
    readAll(tag);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(posedge clk);
    #1;
    readAll("R1");

    // R2: fill the four-deep chain
    step(2'd0, 8'h11, "R2");
    step(2'd0, 8'h22, "R2");
    step(2'd0, 8'h33, "R2");
    step(2'd0, 8'h44, "R2");
    step(2'd0, 8'h55, "R2");

    // R5: hold while din changes
    step(2'd3, 8'hEE, "R5");
    step(2'd3, 8'h99, "R5");

    // R3: bank B only, A untouched
    step(2'd1, 8'hB0, "R3");
    step(2'd1, 8'hB1, "R3");

    // R4: bank A only, B untouched
    step(2'd2, 8'hA0, "R4");
    step(2'd2, 8'hA1, "R4");

    // R9: mode changes on consecutive edges
    step(2'd0, 8'hC0, "R9");
    step(2'd1, 8'hC1, "R9");
    step(2'd0, 8'hC2, "R9");
    step(2'd2, 8'hC3, "R9");
    step(2'd3, 8'hC4, "R9");
    step(2'd0, 8'hC5, "R9");

    // R6: select changes between edges with no clock
    @(negedge clk);
    instr = 2'd3;
    #1;
    readAll("R6");

    // R7: output disabled, then enabled again
    oeN = 1'b1;
    #1;
    readAll("R7");
    oeN = 1'b0;
    #1;
    readAll("R7");

    // R8: reset wins over chain mode with non-zero data
    @(negedge clk);
    rst = 1'b1;
    instr = 2'd0;
    din = 8'h5A;
    @(posedge clk);
    #1;
    mA1 = '0; mA2 = '0; mB1 = '0; mB2 = '0;
    readAll("R8");

    // R1: restart from zero after reset
    step(2'd2, 8'h01, "R1");

    done = 1;
    report();
    $finish;
  end

endmodule